// File: doc/BRIEF.md
# PCI INTx Interrupt Router

The router takes four level-sensitive shared PCI interrupt lines and steers each one onto one of sixteen legacy interrupt-controller inputs. Each shared line has its own byte-wide route register. A route value below 16 names the target line. A value of 16 or more turns that shared line off.

Several shared lines may point at the same output. Each output is the OR of every asserted shared line routed to it. To keep this exact when routes move, the router holds a 64-bit level map, one bit per output/source pair, at index `line*4 + source`. In normal operation only the bit a source currently points at is refreshed. A write that touches the route registers clears the whole map and rebuilds it from the present input levels under the new routes, so a line that has lost its last source drops in the same cycle as the new line rises. Such a write also raises a one-cycle route-changed pulse.

Two helpers sit beside the router, both combinational. The first reports the current route of any source pin. The second turns a device slot number and its INTx pin into a source index with the usual rotating swizzle. There is no data stream here, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `intx_router`

## Requirements
- R1: While reset is active and after it is released, every route register reads 0x80, every `pic_irq` bit is 0 and `route_chg` is 0.
- R2: A write is taken only when `cfg_wr` is 1 and `cfg_dw_addr` equals 0x18, the dword that covers byte offsets 0x60..0x63. Byte lane i (`cfg_be[i]`, `cfg_wdata[8i+7:8i]`) holds the route of source i, with A=0 through D=3. Lanes whose enable is 0 keep their value. Writes to any other dword change nothing.
- R3: `cfg_rdata` returns the four stored route bytes in the same lane order when `cfg_dw_addr` is 0x18, and returns 0 for any other dword.
- R4: A route value of 16 or more disables its source, and that source's level then has no effect on any `pic_irq` bit. Values 0..15 are enabled, with 15 as the top line.
- R5: `pic_irq[l]` is the OR of every asserted source routed to line l. It follows `pirq_lvl` with exactly one clock of latency.
- R6: A route write rebuilds the whole level map from the present `pirq_lvl` under the new routes. One clock after the write, a line with no remaining asserted source is 0 and the new target line reflects the level.
- R7: `route_chg` is 1 for exactly the one cycle after a write taken at dword 0x18 with at least one byte enable set, and is 0 at every other time.
- R8: For source `qry_pin`, `qry_en` is 1 and `qry_irq` equals the route when the route is below 16. Otherwise `qry_en` is 0 and `qry_irq` is 0xFF, which is -1 in two's complement.
- R9: `swz_pirq` equals `(swz_pin + swz_slot - 1) & 3`, where pin 0..3 stands for INTA..INTD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_dw_addr | input | 6 | Config dword address (byte offset / 4) |
| cfg_be | input | 4 | Byte enables, one per source lane |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_dw_addr` |
| pirq_lvl | input | 4 | Shared interrupt levels, active high, bit i = source i |
| pic_irq | output | 16 | Interrupt-controller input levels |
| route_chg | output | 1 | One-cycle pulse after a route write |
| qry_pin | input | 2 | Source index to query |
| qry_en | output | 1 | Queried source is enabled |
| qry_irq | output | 8 | Queried line, or 0xFF when disabled |
| swz_slot | input | 5 | Device slot number (devfn >> 3) |
| swz_pin | input | 2 | Device INTx pin, 0 = INTA |
| swz_pirq | output | 2 | Swizzled source index |

## Verification
The bench drives all four sources asserted while every source is disabled. This separates a real disable from a router that decodes the low route bits anyway. It then places two sources on one line and releases them one at a time, which tells a true OR apart from a last-writer-wins bit. Next it moves a source that is still asserted to a new line, which exposes an incremental update that leaves the old bit stale. Byte-enable patterns with no lanes set, a foreign dword, and the route values 15 and 16 each probe one edge of the write decode and of the enable boundary.

// File: rtl/intx_router_pkg.sv
package intx_router_pkg;
  localparam int unsigned DEF_NUM_PIRQ  = 4;
  localparam int unsigned DEF_NUM_LINES = 16;
  localparam logic [5:0]  DEF_ROUTE_DW  = 6'h18;
  localparam logic [7:0]  ROUTE_RESET   = 8'h80;
  localparam logic [7:0]  QUERY_NONE    = 8'hFF;
  typedef logic [7:0] route_t;
endpackage

// File: rtl/intx_route_regs.sv
module intx_route_regs
  import intx_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ  = DEF_NUM_PIRQ,
  parameter int unsigned NUM_LINES = DEF_NUM_LINES,
  parameter logic [5:0]  ROUTE_DW  = DEF_ROUTE_DW,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES),
  localparam int unsigned PIDX_W   = $clog2(NUM_PIRQ),
  localparam int unsigned DATA_W   = 8 * NUM_PIRQ
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr,
  input  logic [5:0]                       dw_addr,
  input  logic [NUM_PIRQ-1:0]              be,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                rdata,
  output logic [NUM_PIRQ-1:0][LINE_W-1:0]  route_idx,
  output logic [NUM_PIRQ-1:0]              dis_nxt,
  output logic                             rebuild,
  output logic                             route_chg,
  input  logic [PIDX_W-1:0]                qry_pin,
  output logic                             qry_en,
  output logic [7:0]                       qry_irq
);
  route_t [NUM_PIRQ-1:0] route_q;
  route_t [NUM_PIRQ-1:0] route_nxt;
  logic                  addr_hit;
  logic [NUM_PIRQ-1:0]   lane_we;

  assign addr_hit = (dw_addr == ROUTE_DW);
  assign rebuild  = wr && addr_hit && (|be);

  for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_lane
    assign lane_we[i]   = wr && addr_hit && be[i];
    assign route_nxt[i] = lane_we[i] ? wdata[8*i +: 8] : route_q[i];
    assign dis_nxt[i]   = ({1'b0, route_nxt[i]} >= 9'(NUM_LINES));
    assign route_idx[i] = route_nxt[i][LINE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q[i] <= ROUTE_RESET;
      else        route_q[i] <= route_nxt[i];
    end

    assign rdata[8*i +: 8] = addr_hit ? route_q[i] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_chg <= 1'b0;
    else        route_chg <= rebuild;
  end

  route_t qry_sel;
  assign qry_sel = route_q[qry_pin];
  assign qry_en  = ({1'b0, qry_sel} < 9'(NUM_LINES));
  assign qry_irq = qry_en ? qry_sel : QUERY_NONE;

  AST_CHG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr_hit && (|be)) |=> route_chg); // R7
  AST_CHG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr_hit && (|be)) |=> !route_chg); // R7
  AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(route_q)); // R2
endmodule

// File: rtl/intx_level_map.sv
module intx_level_map
  import intx_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ  = DEF_NUM_PIRQ,
  parameter int unsigned NUM_LINES = DEF_NUM_LINES,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES),
  localparam int unsigned MAP_W    = NUM_PIRQ * NUM_LINES
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rebuild,
  input  logic [NUM_PIRQ-1:0]              lvl,
  input  logic [NUM_PIRQ-1:0][LINE_W-1:0]  route_idx,
  input  logic [NUM_PIRQ-1:0]              dis_nxt,
  output logic [NUM_LINES-1:0]             pic
);
  logic [MAP_W-1:0] map_q;
  logic [MAP_W-1:0] map_d;

  // Incremental refresh of the pointed-at bit; full clear on a route write.
  always_comb begin
    int unsigned idx;
    map_d = rebuild ? '0 : map_q;
    for (int p = 0; p < NUM_PIRQ; p++) begin
      idx = int'(route_idx[p]) * NUM_PIRQ + p;
      if (!dis_nxt[p]) map_d[idx] = lvl[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign pic[l] = |map_q[l*NUM_PIRQ +: NUM_PIRQ];
  end

  AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (&dis_nxt) |=> (pic == '0)); // R4
  AST_NO_LEVEL_NO_PIC: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) |=> (pic == '0)); // R5
endmodule

// File: rtl/intx_slot_swizzle.sv
module intx_slot_swizzle
  import intx_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = DEF_NUM_PIRQ,
  localparam int unsigned PIDX_W  = $clog2(NUM_PIRQ)
) (
  input  logic [4:0]        slot,
  input  logic [1:0]        pin,
  output logic [PIDX_W-1:0] pirq
);
  logic [4:0] sum;
  assign sum  = 5'(pin) + slot - 5'd1;
  assign pirq = sum[PIDX_W-1:0];
endmodule

// File: rtl/intx_router.sv
module intx_router
  import intx_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ  = DEF_NUM_PIRQ,
  parameter int unsigned NUM_LINES = DEF_NUM_LINES,
  parameter logic [5:0]  ROUTE_DW  = DEF_ROUTE_DW,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES),
  localparam int unsigned PIDX_W   = $clog2(NUM_PIRQ),
  localparam int unsigned DATA_W   = 8 * NUM_PIRQ
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [5:0]            cfg_dw_addr,
  input  logic [NUM_PIRQ-1:0]   cfg_be,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic [DATA_W-1:0]     cfg_rdata,
  input  logic [NUM_PIRQ-1:0]   pirq_lvl,
  output logic [NUM_LINES-1:0]  pic_irq,
  output logic                  route_chg,
  input  logic [PIDX_W-1:0]     qry_pin,
  output logic                  qry_en,
  output logic [7:0]            qry_irq,
  input  logic [4:0]            swz_slot,
  input  logic [1:0]            swz_pin,
  output logic [PIDX_W-1:0]     swz_pirq
);
  logic [NUM_PIRQ-1:0][LINE_W-1:0] route_idx;
  logic [NUM_PIRQ-1:0]             dis_nxt;
  logic                            rebuild;

  intx_route_regs #(.NUM_PIRQ(NUM_PIRQ), .NUM_LINES(NUM_LINES), .ROUTE_DW(ROUTE_DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .dw_addr(cfg_dw_addr), .be(cfg_be),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .route_idx(route_idx), .dis_nxt(dis_nxt),
    .rebuild(rebuild), .route_chg(route_chg), .qry_pin(qry_pin), .qry_en(qry_en),
    .qry_irq(qry_irq)
  );

  intx_level_map #(.NUM_PIRQ(NUM_PIRQ), .NUM_LINES(NUM_LINES)) u_map (
    .clk(clk), .rst_n(rst_n), .rebuild(rebuild), .lvl(pirq_lvl),
    .route_idx(route_idx), .dis_nxt(dis_nxt), .pic(pic_irq)
  );

  intx_slot_swizzle #(.NUM_PIRQ(NUM_PIRQ)) u_swz (
    .slot(swz_slot), .pin(swz_pin), .pirq(swz_pirq)
  );
endmodule

// File: tb/tb_intx_router.sv
module tb_intx_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dw_addr = 6'h18;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic [3:0]  pirq_lvl = 4'h0;
  logic [15:0] pic_irq;
  logic        route_chg;
  logic [1:0]  qry_pin = 2'd0;
  logic        qry_en;
  logic [7:0]  qry_irq;
  logic [4:0]  swz_slot = 5'd0;
  logic [1:0]  swz_pin = 2'd0;
  logic [1:0]  swz_pirq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  intx_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pirq_lvl(pirq_lvl), .pic_irq(pic_irq), .route_chg(route_chg),
    .qry_pin(qry_pin), .qry_en(qry_en), .qry_irq(qry_irq),
    .swz_slot(swz_slot), .swz_pin(swz_pin), .swz_pirq(swz_pirq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outputs.
  task automatic drive(input logic w, input logic [5:0] a, input logic [3:0] b,
                       input logic [31:0] d, input logic [3:0] l,
                       input logic [15:0] ep, input logic ec, input string tag);
    @(negedge clk);
    cfg_wr = w; cfg_dw_addr = a; cfg_be = b; cfg_wdata = d; pirq_lvl = l;
    exp_q.push_back({ec, ep});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares after each active edge.
  always begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " pic"}, {16'h0, pic_irq}, {16'h0, e[15:0]});
      check({t, " chg"}, {31'h0, route_chg}, {31'h0, e[16]});
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 pic in reset", {16'h0, pic_irq}, 32'h0);
    check("R1 rdata in reset", cfg_rdata, 32'h80808080);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 rdata after reset", cfg_rdata, 32'h80808080);
    check("R1 chg after reset", {31'h0, route_chg}, 32'h0);
    check("R8 query disabled en", {31'h0, qry_en}, 32'h0);
    check("R8 query disabled irq", {24'h0, qry_irq}, 32'hFF);

    drive(1'b0, 6'h18, 4'h0, 32'h0, 4'b1111, 16'h0000, 1'b0, "R4 all disabled");
    drive(1'b1, 6'h18, 4'b0001, 32'h00000003, 4'b1111, 16'h0008, 1'b1, "R6 A to 3");
    drive(1'b0, 6'h18, 4'h0, 32'h0, 4'b1111, 16'h0008, 1'b0, "R5 hold");
    drive(1'b1, 6'h18, 4'b0010, 32'h00000300, 4'b1111, 16'h0008, 1'b1, "R7 B to 3");
    drive(1'b0, 6'h18, 4'h0, 32'h0, 4'b1110, 16'h0008, 1'b0, "R5 OR keeps line");
    drive(1'b0, 6'h18, 4'h0, 32'h0, 4'b1100, 16'h0000, 1'b0, "R5 both released");
    drive(1'b1, 6'h18, 4'b1100, 32'h10050000, 4'b1100, 16'h0020, 1'b1, "R6 C to 5 D off");
    drive(1'b0, 6'h18, 4'h0, 32'h0, 4'b1111, 16'h0028, 1'b0, "R5 two lines");
    drive(1'b0, 6'h18, 4'h0, 32'h0, 4'b0101, 16'h0028, 1'b0, "R5 A and C");
    drive(1'b1, 6'h18, 4'b0001, 32'h00000007, 4'b0101, 16'h00A0, 1'b1, "R6 move A 3 to 7");
    drive(1'b1, 6'h19, 4'b1111, 32'h00000000, 4'b0101, 16'h00A0, 1'b0, "R2 foreign dword");
    #1;
    check("R3 foreign read", cfg_rdata, 32'h0);
    drive(1'b1, 6'h18, 4'b0000, 32'hFFFFFFFF, 4'b0101, 16'h00A0, 1'b0, "R7 no lanes");
    #1;
    check("R3 read routes", cfg_rdata, 32'h10050307);
    qry_pin = 2'd0; #1;
    check("R8 query A en", {31'h0, qry_en}, 32'h1);
    check("R8 query A irq", {24'h0, qry_irq}, 32'h07);
    qry_pin = 2'd3; #1;
    check("R8 query D en", {31'h0, qry_en}, 32'h0);
    check("R8 query D irq", {24'h0, qry_irq}, 32'hFF);
    qry_pin = 2'd1; #1;
    check("R8 query B irq", {24'h0, qry_irq}, 32'h03);

    drive(1'b1, 6'h18, 4'b0001, 32'h00000080, 4'b0101, 16'h0020, 1'b1, "R4 disable A");
    drive(1'b1, 6'h18, 4'b1000, 32'h0F000000, 4'b1000, 16'h8000, 1'b1, "R4 route 15");
    drive(1'b1, 6'h18, 4'b1000, 32'h10000000, 4'b1000, 16'h0000, 1'b1, "R4 route 16");
    drive(1'b0, 6'h18, 4'h0, 32'h0, 4'b1000, 16'h0000, 1'b0, "R7 pulse ends");
    repeat (2) @(posedge clk);
    #3;

    swz_slot = 5'd1; swz_pin = 2'd0; #1;
    check("R9 slot1 INTA", {30'h0, swz_pirq}, 32'd0);
    swz_slot = 5'd0; swz_pin = 2'd0; #1;
    check("R9 slot0 INTA", {30'h0, swz_pirq}, 32'd3);
    swz_slot = 5'd3; swz_pin = 2'd2; #1;
    check("R9 slot3 INTC", {30'h0, swz_pirq}, 32'd0);
    swz_slot = 5'd6; swz_pin = 2'd1; #1;
    check("R9 slot6 INTB", {30'h0, swz_pirq}, 32'd2);
    swz_slot = 5'd31; swz_pin = 2'd3; #1;
    check("R9 slot31 INTD", {30'h0, swz_pirq}, 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule